// File: doc/BRIEF.md
# Markov Miss-Address Prefetcher

This block watches the stream of cache-miss line addresses and learns which miss tends to come next after each miss. A direct-mapped transition table is keyed by a miss address. Each entry stores up to two successor addresses that were seen to follow that key. When a new miss arrives, the block looks up its entry. Each recorded successor becomes a prefetch request.

A register keeps the previous miss address. Every miss after the first trains the entry of that previous miss with the current address as its successor. The block presents requests one per cycle on a valid/ready port through a two-deep queue. The first successor slot goes out before the second. Requests that find no room in the queue are discarded. The cache, the memory side and any arbitration with other prefetchers sit outside this block.

Top module: `markov_prefetcher`

## Requirements
- R1: While reset is held low and after it is released, `pf_valid` is low until a miss has produced a request.
- R2: The first miss after reset trains no entry. The previous-miss register starts invalid, so a later miss to address 0 finds nothing.
- R3: A miss whose entry matches sends its first slot to `pf_addr` in the cycle after the miss. The second slot follows in the next cycle when `pf_ready` is high. A request appears only in the cycle after a miss.
- R4: An empty slot produces no request. A miss whose entry is invalid or holds another tag produces no request.
- R5: Training with a successor that is already stored in either slot leaves the entry unchanged.
- R6: A new successor goes to slot 1 if slot 1 is empty, otherwise to slot 2 if slot 2 is empty. If both slots are full, slot 1 moves into slot 2 and the new successor takes slot 1, so the old slot 2 is lost.
- R7: The table has 2^IDX_W entries, indexed by the low IDX_W bits of the line address. Its tag is the remaining upper bits. Training a key whose tag differs from the stored one reallocates the entry with the new tag, with slot 1 set to the successor and slot 2 empty.
- R8: The queue holds two requests. Requests that find it full are dropped. `pf_addr` holds steady while `pf_valid` is high and `pf_ready` is low.
- R9: In a cycle where a miss both trains and looks up the same entry, the lookup sees the entry as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A miss line address is present this cycle |
| miss_addr | input | ADDR_W | Miss line address |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Consumer accepts the offered request |
| pf_addr | output | ADDR_W | Prefetch line address |

## Verification
Two situations are hard to reach from the ports. The first is an entry whose two slots are both full when a third, different successor arrives. The second is an entry stolen by an aliasing address and then reclaimed. Directed sequences build each case on purpose: one key is followed by three distinct successors, and two addresses that share index bits alternate. The same-cycle case, where training and lookup hit one entry, comes from a miss that repeats itself. The random phase then draws from a small pool of addresses with few indices and several tags. This keeps hits, aliasing and queue overflow frequent while `pf_ready` toggles.

// File: rtl/mkv_pkg.sv
// Shared types for the Markov miss-address prefetcher.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package mkv_pkg;
    // Action taken on one table entry when a transition is trained.
    typedef enum logic [2:0] {
        TR_KEEP,   // successor already known
        TR_ALLOC,  // tag mismatch: claim entry
        TR_FILL1,  // slot 1 empty
        TR_FILL2,  // slot 2 empty
        TR_SHIFT   // both full: slot1 -> slot2, new -> slot1
    } train_act_t;
endpackage

// File: rtl/mkv_train_dec.sv
// Decides how one transition updates a table entry.
// Assumes: slot 2 is never valid while slot 1 is empty.
module mkv_train_dec #(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  logic              s1_v,
    input  logic [ADDR_W-1:0] s1,
    input  logic              s2_v,
    input  logic [ADDR_W-1:0] s2,
    input  logic [ADDR_W-1:0] succ,
    output mkv_pkg::train_act_t act
);
    import mkv_pkg::*;

    // Priority choice of the update action.
    always_comb begin
        if (!hit)                                         act = TR_ALLOC;
        else if ((s1_v && s1 == succ) || (s2_v && s2 == succ)) act = TR_KEEP;
        else if (!s1_v)                                   act = TR_FILL1;
        else if (!s2_v)                                   act = TR_FILL2;
        else                                              act = TR_SHIFT;
    end
endmodule

// File: rtl/mkv_table.sv
// Direct-mapped transition table with two successor slots per entry.
// Lookup is combinational from the stored state; training writes at the
// clock edge, so a same-cycle lookup sees the pre-update contents.
// Assumes: tr_key and lk_addr are full line addresses.
module mkv_table #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_s1_v,
    output logic [ADDR_W-1:0] lk_s1,
    output logic              lk_s2_v,
    output logic [ADDR_W-1:0] lk_s2,
    input  logic              tr_en,
    input  logic [ADDR_W-1:0] tr_key,
    input  logic [ADDR_W-1:0] tr_succ
);
    import mkv_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W;

    logic [ENTRIES-1:0] ent_v, s1_v, s2_v;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  s1_q  [ENTRIES];
    logic [ADDR_W-1:0]  s2_q  [ENTRIES];

    logic [IDX_W-1:0] lk_idx, tr_idx;
    logic [TAG_W-1:0] lk_tag, tr_tag;
    logic             lk_hit, tr_hit;
    train_act_t       act;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
    assign tr_idx = tr_key[IDX_W-1:0];
    assign tr_tag = tr_key[ADDR_W-1:IDX_W];

    // Lookup of the entry addressed by the current miss.
    always_comb begin
        lk_hit  = ent_v[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_s1_v = lk_hit && s1_v[lk_idx];
        lk_s1   = s1_q[lk_idx];
        lk_s2_v = lk_hit && s2_v[lk_idx];
        lk_s2   = s2_q[lk_idx];
        tr_hit  = ent_v[tr_idx] && (tag_q[tr_idx] == tr_tag);
    end

    mkv_train_dec #(.ADDR_W(ADDR_W)) u_dec (
        .hit  (tr_hit),
        .s1_v (s1_v[tr_idx]),
        .s1   (s1_q[tr_idx]),
        .s2_v (s2_v[tr_idx]),
        .s2   (s2_q[tr_idx]),
        .succ (tr_succ),
        .act  (act)
    );

    // Valid bits: cleared by reset, updated by training.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            s1_v  <= '0;
            s2_v  <= '0;
        end else if (tr_en) begin
            unique case (act)
                TR_ALLOC: begin
                    ent_v[tr_idx] <= 1'b1;
                    s1_v[tr_idx]  <= 1'b1;
                    s2_v[tr_idx]  <= 1'b0;
                end
                TR_FILL1: s1_v[tr_idx] <= 1'b1;
                TR_FILL2: s2_v[tr_idx] <= 1'b1;
                default: ;
            endcase
        end
    end

    // Tag and successor storage, written only on training.
    always_ff @(posedge clk) begin
        if (tr_en) begin
            unique case (act)
                TR_ALLOC: begin
                    tag_q[tr_idx] <= tr_tag;
                    s1_q[tr_idx]  <= tr_succ;
                end
                TR_FILL1: s1_q[tr_idx] <= tr_succ;
                TR_FILL2: s2_q[tr_idx] <= tr_succ;
                TR_SHIFT: begin
                    s2_q[tr_idx] <= s1_q[tr_idx];
                    s1_q[tr_idx] <= tr_succ;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mkv_queue.sv
// Small output queue taking up to two pushes and one pop per cycle.
// A pop frees its slot for the same cycle's pushes; pushes that find
// no free slot are dropped. Push A is placed before push B.
// Assumes: DEPTH >= 1.
module mkv_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_a_v,
    input  logic [W-1:0] push_a,
    input  logic         push_b_v,
    input  logic [W-1:0] push_b,
    output logic         out_v,
    output logic [W-1:0] out_d,
    input  logic         out_rdy
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     data_q [DEPTH];
    logic [W-1:0]     nxt_d  [DEPTH];
    logic [CNT_W-1:0] cnt_q, nxt_n;

    assign out_v = (cnt_q != '0);
    assign out_d = data_q[0];

    // Next contents: pop first, then append A and B if room remains.
    always_comb begin
        nxt_d = data_q;
        nxt_n = cnt_q;
        if (out_rdy && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) nxt_d[i] = data_q[i+1];
            nxt_n = cnt_q - CNT_W'(1);
        end
        if (push_a_v && nxt_n < CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == nxt_n) nxt_d[i] = push_a;
            nxt_n = nxt_n + CNT_W'(1);
        end
        if (push_b_v && nxt_n < CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == nxt_n) nxt_d[i] = push_b;
            nxt_n = nxt_n + CNT_W'(1);
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt_n;
    end

    // Payload registers.
    always_ff @(posedge clk) begin
        data_q <= nxt_d;
    end
endmodule

// File: rtl/markov_prefetcher.sv
// Markov miss-address prefetcher top. Each miss looks up its own entry
// to issue prefetches and trains the entry of the previous miss.
// Assumes: miss_addr is a line address; one miss per cycle at most.
module markov_prefetcher #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 5,
    parameter int Q_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic              last_v;
    logic [ADDR_W-1:0] last_q;
    logic              s1_v, s2_v;
    logic [ADDR_W-1:0] s1, s2;

    // Previous-miss history register (history of one).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_v <= 1'b0;
            last_q <= '0;
        end else if (miss_valid) begin
            last_v <= 1'b1;
            last_q <= miss_addr;
        end
    end

    mkv_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (miss_addr),
        .lk_s1_v (s1_v),
        .lk_s1   (s1),
        .lk_s2_v (s2_v),
        .lk_s2   (s2),
        .tr_en   (miss_valid && last_v),
        .tr_key  (last_q),
        .tr_succ (miss_addr)
    );

    mkv_queue #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_a_v (miss_valid && s1_v),
        .push_a   (s1),
        .push_b_v (miss_valid && s2_v),
        .push_b   (s2),
        .out_v    (pf_valid),
        .out_d    (pf_addr),
        .out_rdy  (pf_ready)
    );
endmodule

// File: rtl/mkv_checker.sv
// Protocol and history checks for markov_prefetcher, bound to every instance.
// Assumes: synchronous active-low reset.
module mkv_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic [ADDR_W-1:0] miss_addr,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              last_v,
    input logic [ADDR_W-1:0] last_q
);
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R8

    AST_NO_REQ_WITHOUT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_valid && !miss_valid |=> !pf_valid); // R4

    AST_REQ_FOLLOWS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(miss_valid)); // R3

    AST_HISTORY_TRACKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> last_v && last_q == $past(miss_addr)); // R2
endmodule

bind markov_prefetcher mkv_checker #(.ADDR_W(ADDR_W)) u_mkv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .last_v     (last_v),
    .last_q     (last_q)
);

// File: tb/markov_prefetcher_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a requirement-level model of the table, history register and queue.
module markov_prefetcher_bench;
    localparam int  ADDR_W  = 32;
    localparam int  IDX_W   = 5;
    localparam int  ENT     = 1 << IDX_W;
    localparam time PERIOD  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic              pf_valid;
    logic              pf_ready = 1'b0;
    logic [ADDR_W-1:0] pf_addr;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state.
    logic              m_ent [ENT];
    logic [ADDR_W-1:0] m_tag [ENT];
    logic              m_v1 [ENT];
    logic [ADDR_W-1:0] m_s1 [ENT];
    logic              m_v2 [ENT];
    logic [ADDR_W-1:0] m_s2 [ENT];
    logic              m_lv;
    logic [ADDR_W-1:0] m_last;
    logic [ADDR_W-1:0] mq [2];
    int                mcnt;

    always #(PERIOD/2) clk = ~clk;

    markov_prefetcher u_markov_prefetcher (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    task automatic check(input logic ok, input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ENT; i++) begin
            m_ent[i] = 0; m_v1[i] = 0; m_v2[i] = 0;
            m_tag[i] = '0; m_s1[i] = '0; m_s2[i] = '0;
        end
        m_lv = 0; m_last = '0; mcnt = 0; mq[0] = '0; mq[1] = '0;
    endtask

    task automatic model_push(input logic v, input logic [ADDR_W-1:0] a);
        if (v && mcnt < 2) begin mq[mcnt] = a; mcnt++; end
    endtask

    // Applies one cycle of inputs to the model.
    task automatic model_step(input logic mv, input logic [ADDR_W-1:0] a, input logic rdy);
        logic [IDX_W-1:0] li, ti;
        logic hit, pav, pbv, known;
        logic [ADDR_W-1:0] pa, pb;
        li  = idx_of(a);
        hit = mv && m_ent[li] && (m_tag[li] >> IDX_W) == (a >> IDX_W);
        pav = hit && m_v1[li]; pa = m_s1[li];
        pbv = hit && m_v2[li]; pb = m_s2[li];
        if (rdy && mcnt > 0) begin mq[0] = mq[1]; mcnt--; end
        model_push(pav, pa);
        model_push(pbv, pb);
        if (mv && m_lv) begin
            ti = idx_of(m_last);
            if (!(m_ent[ti] && (m_tag[ti] >> IDX_W) == (m_last >> IDX_W))) begin
                m_ent[ti] = 1; m_tag[ti] = m_last;
                m_v1[ti] = 1; m_s1[ti] = a; m_v2[ti] = 0;
            end else begin
                known = (m_v1[ti] && m_s1[ti] == a) || (m_v2[ti] && m_s2[ti] == a);
                if (!known) begin
                    if (!m_v1[ti]) begin m_v1[ti] = 1; m_s1[ti] = a; end
                    else if (!m_v2[ti]) begin m_v2[ti] = 1; m_s2[ti] = a; end
                    else begin m_s2[ti] = m_s1[ti]; m_s1[ti] = a; end
                end
            end
        end
        if (mv) begin m_lv = 1; m_last = a; end
    endtask

    // Drives one cycle, then compares the outputs against the model.
    task automatic step(input logic mv, input logic [ADDR_W-1:0] a, input logic rdy);
        miss_valid = mv; miss_addr = a; pf_ready = rdy;
        model_step(mv, a, rdy);
        @(posedge clk);
        @(negedge clk);
        check(pf_valid === (mcnt > 0), "R3/R8 valid", ADDR_W'(pf_valid), ADDR_W'(mcnt > 0));
        if (mcnt > 0) check(pf_addr === mq[0], "R3/R6 addr", pf_addr, mq[0]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1);
    endtask

    task automatic expect_out(input logic v, input logic [ADDR_W-1:0] a, input string req);
        check(pf_valid === v, req, ADDR_W'(pf_valid), ADDR_W'(v));
        if (v) check(pf_addr === a, req, pf_addr, a);
    endtask

    localparam logic [ADDR_W-1:0] A = 32'h101, B = 32'h202, C = 32'h303,
                                  D = 32'h404, E = 32'h501, F = 32'h606, G = 32'h707;

    initial begin
        #(PERIOD * 200000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int seed;
        logic mv, rdy;
        logic [ADDR_W-1:0] a;
        seed = 12345;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        check(pf_valid === 1'b0, "R1 reset", ADDR_W'(pf_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pf_valid === 1'b0, "R1 after reset", ADDR_W'(pf_valid), '0);

        // R2: first miss trains nothing (address 0 stays unknown).
        step(1, G, 1); idle(3);
        step(1, 32'h0, 1); expect_out(0, '0, "R2 first miss untrained");
        // R3: slot 1 then slot 2 in order.
        step(1, A, 1); step(1, B, 1);
        step(1, A, 1); expect_out(1, B, "R3 single successor");
        step(1, C, 1); expect_out(0, '0, "R4 empty lookup");
        step(1, A, 1); expect_out(1, B, "R3 slot 1 first");
        step(0, '0, 1); expect_out(1, C, "R3 slot 2 next");
        step(0, '0, 1); expect_out(0, '0, "R3 drained");
        // R6: third successor shifts.
        step(1, D, 1);
        step(1, A, 1); expect_out(1, D, "R6 new in slot 1");
        step(0, '0, 1); expect_out(1, B, "R6 old slot 1 in slot 2");
        // R5: known successor unchanged.
        step(1, B, 1); expect_out(1, A, "R5 lookup B");
        step(1, A, 1); expect_out(1, D, "R5 unchanged entry");
        idle(3);
        // R7: aliasing reallocation.
        step(1, E, 1); expect_out(0, '0, "R7 alias tag mismatch");
        step(1, B, 1); expect_out(1, A, "R7 lookup B");
        step(1, A, 1); expect_out(0, '0, "R7 entry taken by alias");
        step(1, E, 1); expect_out(1, B, "R7 alias owns entry");
        idle(3);
        // R8: overflow drops, stall holds.
        step(1, C, 1); step(1, B, 1); idle(3);
        step(1, C, 0); expect_out(1, A, "R8 head");
        step(1, C, 0); expect_out(1, A, "R8 stall holds");
        step(0, '0, 1); expect_out(1, B, "R8 second entry");
        step(0, '0, 1); expect_out(0, '0, "R8 overflow dropped");
        idle(3);
        // R9: same-cycle train and lookup.
        step(1, F, 1);
        step(1, F, 1); expect_out(0, '0, "R9 lookup sees old entry");
        step(1, F, 1); expect_out(1, F, "R9 update visible next miss");
        idle(3);

        // Random traffic over a small aliasing pool.
        for (int n = 0; n < 4000; n++) begin
            mv  = ($urandom % 10) < 6;
            rdy = ($urandom % 10) < 7;
            a   = (ADDR_W'($urandom % 3) << IDX_W) | ADDR_W'($urandom % 4);
            step(mv, a, rdy);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule